// File: doc/BRIEF.md
# Parallel Predicated Branch Resolver

This block settles the conditional branches that one instruction issues across several flow slots at the same time. Each slot may carry one branch. A branch has a sense bit that selects whether it is taken on a false predicate or on a true one. It also has a signed offset, taken either from a literal field or from an operand field, and an unsigned delay in cycles. The block counts down each branch's delay on its own. When the delay runs out, it reads that slot's predicate input. Among the taken branches that resolve in the same cycle, the lowest-numbered slot wins. The redirect target is the entry address of the current code block plus the winning offset.

Each slot runs a two-state machine. SLOT_IDLE holds no branch. SLOT_WAIT holds a delayed branch while its counter runs down. The slot moves from SLOT_IDLE to SLOT_WAIT on an issue with a nonzero delay. It returns to SLOT_IDLE when the counter expires, when a redirect flushes it, or when a zero-delay issue replaces its branch. The output machine also has two states. RD_QUIET means no redirect. RD_PULSE means redirect_valid is high. The machine enters RD_PULSE in any cycle where a taken branch resolved, and otherwise stays in or returns to RD_QUIET.

When a redirect is decided, every pending branch is dropped, and the new target becomes the base for later branches. A separate load input sets the base when the surrounding pipeline enters a new code block.

Top module: `branch_resolver`

## Requirements
- R1: A synchronous active-high reset deasserts redirect_valid, sets the base to 0 and drops every pending branch, so a branch issued before the reset never redirects.
- R2: A slot with slot_on_true=0 is taken only when its predicate is 0; with predicate 1 no redirect occurs.
- R3: A slot with slot_on_true=1 is taken only when its predicate is 1; with predicate 0 no redirect occurs.
- R4: A branch with delay 0 samples slot_pred in its issue cycle and raises redirect_valid in the following cycle.
- R5: A branch with delay d>0 samples slot_pred only in the d-th cycle after issue, and redirect_valid rises in the cycle after that. Predicate values in earlier cycles have no effect. No redirect occurs unless a branch resolves taken.
- R6: When several taken branches resolve in the same cycle, the lowest-numbered slot supplies the target.
- R7: A taken branch that resolves earlier wins over a branch that is still waiting, and the waiting branch is discarded.
- R8: redirect_valid is high for one cycle per redirect, and the target becomes the base for later branches.
- R9: slot_use_opnd=1 selects that slot's operand offset field; 0 selects its literal field.
- R10: The offset is two's complement, sign-extended to the address width, and the sum wraps modulo 2^ADDR_W.
- R11: A branch that resolves not taken produces no output, and other slots' branches still resolve on their own delays.
- R12: entry_load replaces the base with entry_addr. If a redirect is decided in the same cycle, the redirect target becomes the base and the load is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| issue_valid | input | 1 | An instruction issues branches this cycle |
| slot_en | input | NUM_SLOTS | Per slot: this slot carries a branch |
| slot_on_true | input | NUM_SLOTS | Per slot sense: 1 taken on true, 0 taken on false |
| slot_pred | input | NUM_SLOTS | Per slot predicate, read when the branch resolves |
| slot_use_opnd | input | NUM_SLOTS | Per slot offset source: 1 operand, 0 literal |
| slot_lit_off | input | NUM_SLOTS*OFF_W | Literal offsets, slot i at bits [i*OFF_W +: OFF_W] |
| slot_opnd_off | input | NUM_SLOTS*OFF_W | Operand offsets, same packing |
| slot_delay | input | NUM_SLOTS*DLY_W | Delays in cycles, slot i at bits [i*DLY_W +: DLY_W] |
| entry_load | input | 1 | Load a new base address |
| entry_addr | input | ADDR_W | Base address to load |
| redirect_valid | output | 1 | One-cycle redirect strobe |
| redirect_target | output | ADDR_W | Target of the latest redirect |

## Verification
A zero-delay branch is due one clock edge after its issue edge. A branch with delay d is due d+1 edges after issue, and its predicate counts only at the d-th edge. The bench changes inputs on falling edges and reads redirect_valid and redirect_target on the falling edge that follows each rising edge. It checks the strobe low at every earlier sample, so a result that comes a cycle early or late is reported. Flushing and rebasing are observed through later redirects and their targets.

// File: rtl/brres_pkg.sv
package brres_pkg;

    typedef enum logic [0:0] {
        SLOT_IDLE,
        SLOT_WAIT
    } slot_state_e;

    typedef enum logic [0:0] {
        RD_QUIET,
        RD_PULSE
    } rd_state_e;

    // Taken when the predicate matches the sense bit.
    function automatic logic br_taken(input logic on_true, input logic pred);
        return on_true ? pred : !pred;
    endfunction

endpackage

// File: rtl/br_slot_ctrl.sv
module br_slot_ctrl
    import brres_pkg::*;
#(
    parameter int OFF_W = 16,
    parameter int DLY_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             flush,
    input  logic             issue,
    input  logic             en,
    input  logic             on_true,
    input  logic             use_opnd,
    input  logic [OFF_W-1:0] lit_off,
    input  logic [OFF_W-1:0] opnd_off,
    input  logic [DLY_W-1:0] delay,
    input  logic             pred,
    output logic             fire,
    output logic [OFF_W-1:0] fire_off,
    output logic             pending
);

    slot_state_e      state_q, state_d;
    logic [DLY_W-1:0] cnt_q, cnt_d;
    logic [OFF_W-1:0] off_q, off_d;
    logic             sense_q, sense_d;

    logic             load_now;
    logic             no_delay;
    logic             expire;
    logic [OFF_W-1:0] new_off;

    assign load_now = issue && en;
    assign no_delay = (delay == '0);
    assign new_off  = use_opnd ? opnd_off : lit_off;
    assign expire   = (state_q == SLOT_WAIT) && (cnt_q == DLY_W'(1));

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SLOT_IDLE;
            cnt_q   <= '0;
            off_q   <= '0;
            sense_q <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            off_q   <= off_d;
            sense_q <= sense_d;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        off_d   = off_q;
        sense_d = sense_q;
        if (flush) begin
            state_d = SLOT_IDLE;
        end else if (load_now) begin
            off_d   = new_off;
            sense_d = on_true;
            cnt_d   = delay;
            state_d = no_delay ? SLOT_IDLE : SLOT_WAIT;
        end else begin
            unique case (state_q)
                SLOT_IDLE: state_d = SLOT_IDLE;
                SLOT_WAIT: begin
                    if (cnt_q == DLY_W'(1)) begin
                        state_d = SLOT_IDLE;
                    end else begin
                        cnt_d = cnt_q - DLY_W'(1);
                    end
                end
                default:   state_d = SLOT_IDLE;
            endcase
        end
    end

    // Outputs: a fresh zero-delay branch replaces any expiring one
    always_comb begin
        fire     = 1'b0;
        fire_off = off_q;
        if (load_now && no_delay) begin
            fire     = br_taken(on_true, pred);
            fire_off = new_off;
        end else if (expire && !load_now) begin
            fire     = br_taken(sense_q, pred);
        end
        pending = (state_q == SLOT_WAIT);
    end

endmodule

// File: rtl/br_pick.sv
module br_pick #(
    parameter int NUM_SLOTS = 3,
    parameter int OFF_W     = 16
) (
    input  logic [NUM_SLOTS-1:0]       fire,
    input  logic [NUM_SLOTS*OFF_W-1:0] offs,
    output logic                       any,
    output logic [OFF_W-1:0]           off
);

    // Scan from the top so the lowest firing slot is written last.
    always_comb begin
        any = |fire;
        off = '0;
        for (int i = NUM_SLOTS - 1; i >= 0; i--) begin
            if (fire[i]) begin
                off = offs[i*OFF_W +: OFF_W];
            end
        end
    end

endmodule

// File: rtl/br_target.sv
module br_target
    import brres_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int OFF_W  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              take,
    input  logic [OFF_W-1:0]  off,
    input  logic              entry_load,
    input  logic [ADDR_W-1:0] entry_addr,
    output logic              redirect_valid,
    output logic [ADDR_W-1:0] redirect_target,
    output logic [ADDR_W-1:0] base_addr
);

    localparam int EXT_W = ADDR_W - OFF_W;

    rd_state_e         rd_state_q, rd_state_d;
    logic [ADDR_W-1:0] base_q;
    logic [ADDR_W-1:0] target_q;
    logic [ADDR_W-1:0] sum;

    assign sum = base_q + {{EXT_W{off[OFF_W-1]}}, off};

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            rd_state_q <= RD_QUIET;
            base_q     <= '0;
            target_q   <= '0;
        end else begin
            rd_state_q <= rd_state_d;
            if (take) begin
                target_q <= sum;
                base_q   <= sum;
            end else if (entry_load) begin
                base_q   <= entry_addr;
            end
        end
    end

    always_comb begin
        unique case (rd_state_q)
            RD_QUIET: rd_state_d = take ? RD_PULSE : RD_QUIET;
            RD_PULSE: rd_state_d = take ? RD_PULSE : RD_QUIET;
            default:  rd_state_d = RD_QUIET;
        endcase
    end

    // Outputs
    always_comb begin
        redirect_valid  = (rd_state_q == RD_PULSE);
        redirect_target = target_q;
        base_addr       = base_q;
    end

endmodule

// File: rtl/branch_resolver.sv
module branch_resolver #(
    parameter int NUM_SLOTS = 3,
    parameter int ADDR_W    = 32,
    parameter int OFF_W     = 16,
    parameter int DLY_W     = 4
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       issue_valid,
    input  logic [NUM_SLOTS-1:0]       slot_en,
    input  logic [NUM_SLOTS-1:0]       slot_on_true,
    input  logic [NUM_SLOTS-1:0]       slot_pred,
    input  logic [NUM_SLOTS-1:0]       slot_use_opnd,
    input  logic [NUM_SLOTS*OFF_W-1:0] slot_lit_off,
    input  logic [NUM_SLOTS*OFF_W-1:0] slot_opnd_off,
    input  logic [NUM_SLOTS*DLY_W-1:0] slot_delay,
    input  logic                       entry_load,
    input  logic [ADDR_W-1:0]          entry_addr,
    output logic                       redirect_valid,
    output logic [ADDR_W-1:0]          redirect_target
);

    logic [NUM_SLOTS-1:0]       slot_fire;
    logic [NUM_SLOTS-1:0]       slot_pend;
    logic [NUM_SLOTS*OFF_W-1:0] slot_fire_off;
    logic                       take;
    logic [OFF_W-1:0]           win_off;
    logic [ADDR_W-1:0]          base_addr;

    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
        br_slot_ctrl #(
            .OFF_W (OFF_W),
            .DLY_W (DLY_W)
        ) i_slot (
            .clk      (clk),
            .rst      (rst),
            .flush    (take),
            .issue    (issue_valid),
            .en       (slot_en[s]),
            .on_true  (slot_on_true[s]),
            .use_opnd (slot_use_opnd[s]),
            .lit_off  (slot_lit_off[s*OFF_W +: OFF_W]),
            .opnd_off (slot_opnd_off[s*OFF_W +: OFF_W]),
            .delay    (slot_delay[s*DLY_W +: DLY_W]),
            .pred     (slot_pred[s]),
            .fire     (slot_fire[s]),
            .fire_off (slot_fire_off[s*OFF_W +: OFF_W]),
            .pending  (slot_pend[s])
        );
    end

    br_pick #(
        .NUM_SLOTS (NUM_SLOTS),
        .OFF_W     (OFF_W)
    ) i_pick (
        .fire (slot_fire),
        .offs (slot_fire_off),
        .any  (take),
        .off  (win_off)
    );

    br_target #(
        .ADDR_W (ADDR_W),
        .OFF_W  (OFF_W)
    ) i_target (
        .clk             (clk),
        .rst             (rst),
        .take            (take),
        .off             (win_off),
        .entry_load      (entry_load),
        .entry_addr      (entry_addr),
        .redirect_valid  (redirect_valid),
        .redirect_target (redirect_target),
        .base_addr       (base_addr)
    );

endmodule

// File: rtl/branch_resolver_chk.sv
module branch_resolver_chk #(
    parameter int NUM_SLOTS = 3,
    parameter int ADDR_W    = 32,
    parameter int OFF_W     = 16,
    parameter int DLY_W     = 4
) (
    input logic                       clk,
    input logic                       rst,
    input logic                       issue_valid,
    input logic [NUM_SLOTS-1:0]       slot_en,
    input logic [NUM_SLOTS-1:0]       slot_on_true,
    input logic [NUM_SLOTS-1:0]       slot_pred,
    input logic [NUM_SLOTS-1:0]       slot_use_opnd,
    input logic [NUM_SLOTS*OFF_W-1:0] slot_lit_off,
    input logic [NUM_SLOTS*OFF_W-1:0] slot_opnd_off,
    input logic [NUM_SLOTS*DLY_W-1:0] slot_delay,
    input logic                       redirect_valid,
    input logic [ADDR_W-1:0]          redirect_target,
    input logic [NUM_SLOTS-1:0]       slot_pend,
    input logic [ADDR_W-1:0]          base_addr
);

    localparam int EXT_W = ADDR_W - OFF_W;

    logic              rst_q;
    logic              slot0_hit;
    logic [OFF_W-1:0]  slot0_off;
    logic [ADDR_W-1:0] slot0_ext;

    assign slot0_off = slot_use_opnd[0] ? slot_opnd_off[OFF_W-1:0] : slot_lit_off[OFF_W-1:0];
    assign slot0_ext = {{EXT_W{slot0_off[OFF_W-1]}}, slot0_off};
    assign slot0_hit = issue_valid && slot_en[0] && (slot_delay[DLY_W-1:0] == '0)
                       && (slot_on_true[0] == slot_pred[0]);

    always_ff @(posedge clk) begin
        rst_q <= rst;
        if (rst_q) begin
            p_reset_quiet_r1: assert (!redirect_valid)
                else $error("redirect_valid high right after reset");
        end
    end

    p_zero_delay_r4: assert property (@(posedge clk) disable iff (rst)
        slot0_hit |=> redirect_valid);

    p_quiet_r5: assert property (@(posedge clk) disable iff (rst)
        (!issue_valid && slot_pend == '0) |=> !redirect_valid);

    p_low_slot_target_r6: assert property (@(posedge clk) disable iff (rst)
        slot0_hit |=> redirect_target == $past(base_addr) + $past(slot0_ext));

    p_flush_r7: assert property (@(posedge clk) disable iff (rst)
        redirect_valid |-> slot_pend == '0);

    p_rebase_r8: assert property (@(posedge clk) disable iff (rst)
        redirect_valid |-> base_addr == redirect_target);

endmodule

bind branch_resolver branch_resolver_chk #(
    .NUM_SLOTS (NUM_SLOTS),
    .ADDR_W    (ADDR_W),
    .OFF_W     (OFF_W),
    .DLY_W     (DLY_W)
) i_chk (
    .clk             (clk),
    .rst             (rst),
    .issue_valid     (issue_valid),
    .slot_en         (slot_en),
    .slot_on_true    (slot_on_true),
    .slot_pred       (slot_pred),
    .slot_use_opnd   (slot_use_opnd),
    .slot_lit_off    (slot_lit_off),
    .slot_opnd_off   (slot_opnd_off),
    .slot_delay      (slot_delay),
    .redirect_valid  (redirect_valid),
    .redirect_target (redirect_target),
    .slot_pend       (slot_pend),
    .base_addr       (base_addr)
);

// File: tb/test_branch_resolver.sv
module test_branch_resolver;

    localparam int NS = 3;
    localparam int AW = 32;
    localparam int OW = 16;
    localparam int DW = 4;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           issue_valid = 1'b0;
    logic [NS-1:0]  en = '0, on_true = '0, pred = '0, use_op = '0;
    logic [NS*OW-1:0] lit = '0, opnd = '0;
    logic [NS*DW-1:0] dly = '0;
    logic           entry_load = 1'b0;
    logic [AW-1:0]  entry_addr = '0;
    logic           rv;
    logic [AW-1:0]  tgt;

    int             checks = 0;
    int             errors = 0;
    bit             done = 1'b0;
    logic [AW-1:0]  exp_base = '0;

    always #5 clk = ~clk;

    branch_resolver #(
        .NUM_SLOTS (NS),
        .ADDR_W    (AW),
        .OFF_W     (OW),
        .DLY_W     (DW)
    ) i_branch_resolver (
        .clk             (clk),
        .rst             (rst),
        .issue_valid     (issue_valid),
        .slot_en         (en),
        .slot_on_true    (on_true),
        .slot_pred       (pred),
        .slot_use_opnd   (use_op),
        .slot_lit_off    (lit),
        .slot_opnd_off   (opnd),
        .slot_delay      (dly),
        .entry_load      (entry_load),
        .entry_addr      (entry_addr),
        .redirect_valid  (rv),
        .redirect_target (tgt)
    );

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic check_rv(input string req, input logic exp_v, input logic [AW-1:0] exp_t);
        checks++;
        if (rv !== exp_v || (exp_v && tgt !== exp_t)) begin
            errors++;
            $display("FAIL %s: valid=%0b target=%h, expected valid=%0b target=%h",
                     req, rv, tgt, exp_v, exp_t);
        end
        if (exp_v) exp_base = exp_t;
    endtask

    task automatic set_slot(input int s, input logic t, input logic uo,
                            input logic [OW-1:0] l, input logic [OW-1:0] o,
                            input logic [DW-1:0] d);
        en[s]            = 1'b1;
        on_true[s]       = t;
        use_op[s]        = uo;
        lit[s*OW +: OW]  = l;
        opnd[s*OW +: OW] = o;
        dly[s*DW +: DW]  = d;
    endtask

    task automatic issue();
        issue_valid = 1'b1;
        tick();
        issue_valid = 1'b0;
        en = '0;
    endtask

    task automatic load_base(input logic [AW-1:0] a);
        entry_load = 1'b1;
        entry_addr = a;
        tick();
        entry_load = 1'b0;
        exp_base = a;
    endtask

    task automatic t_reset();
        check_rv("R1", 1'b0, '0);
        set_slot(0, 1'b0, 1'b0, 16'h0010, 16'h0, 4'd3);
        pred = '0;
        issue();
        tick();
        rst = 1'b1;
        tick();
        rst = 1'b0;
        exp_base = '0;
        for (int k = 0; k < 4; k++) begin
            tick();
            check_rv("R1", 1'b0, '0);
        end
    endtask

    task automatic t_sense();
        load_base(32'h0000_1000);
        set_slot(0, 1'b0, 1'b0, 16'h0020, 16'h0, 4'd0);
        pred = 3'b000;
        issue();
        check_rv("R2 R4", 1'b1, exp_base + 32'h20);
        tick();
        check_rv("R8", 1'b0, '0);
        set_slot(0, 1'b0, 1'b0, 16'h0020, 16'h0, 4'd0);
        pred = 3'b001;
        issue();
        check_rv("R2", 1'b0, '0);
        set_slot(0, 1'b1, 1'b0, 16'h0010, 16'h0, 4'd0);
        pred = 3'b001;
        issue();
        check_rv("R3", 1'b1, exp_base + 32'h10);
        set_slot(0, 1'b1, 1'b0, 16'h0010, 16'h0, 4'd0);
        pred = 3'b000;
        issue();
        check_rv("R3", 1'b0, '0);
    endtask

    task automatic t_delay();
        load_base(32'h0000_2000);
        set_slot(1, 1'b1, 1'b0, 16'h0040, 16'h0, 4'd3);
        pred = 3'b010;
        issue();
        pred = 3'b010; tick(); check_rv("R5", 1'b0, '0);
        pred = 3'b010; tick(); check_rv("R5", 1'b0, '0);
        pred = 3'b000; tick(); check_rv("R5", 1'b0, '0);
        tick(); check_rv("R5", 1'b0, '0);
        set_slot(1, 1'b1, 1'b0, 16'h0040, 16'h0, 4'd3);
        issue();
        pred = 3'b000; tick(); check_rv("R5", 1'b0, '0);
        tick(); check_rv("R5", 1'b0, '0);
        pred = 3'b010; tick(); check_rv("R5", 1'b1, exp_base + 32'h40);
        pred = 3'b000;
    endtask

    task automatic t_priority();
        set_slot(0, 1'b1, 1'b0, 16'h0100, 16'h0, 4'd0);
        set_slot(1, 1'b1, 1'b0, 16'h0200, 16'h0, 4'd0);
        set_slot(2, 1'b1, 1'b0, 16'h0300, 16'h0, 4'd0);
        pred = 3'b111;
        issue();
        check_rv("R6", 1'b1, exp_base + 32'h100);
        set_slot(0, 1'b1, 1'b0, 16'h0100, 16'h0, 4'd0);
        set_slot(1, 1'b1, 1'b0, 16'h0200, 16'h0, 4'd0);
        set_slot(2, 1'b1, 1'b0, 16'h0300, 16'h0, 4'd0);
        pred = 3'b110;
        issue();
        check_rv("R6", 1'b1, exp_base + 32'h200);
    endtask

    task automatic t_earliest();
        set_slot(0, 1'b1, 1'b0, 16'h0500, 16'h0, 4'd3);
        set_slot(2, 1'b1, 1'b0, 16'h0060, 16'h0, 4'd0);
        pred = 3'b100;
        issue();
        check_rv("R7", 1'b1, exp_base + 32'h60);
        pred = 3'b001;
        for (int k = 0; k < 4; k++) begin
            tick();
            check_rv("R7", 1'b0, '0);
        end
        pred = 3'b000;
    endtask

    task automatic t_opsel();
        set_slot(1, 1'b0, 1'b1, 16'h0011, 16'h0022, 4'd0);
        pred = 3'b000;
        issue();
        check_rv("R9", 1'b1, exp_base + 32'h22);
        set_slot(1, 1'b0, 1'b0, 16'h0011, 16'h0022, 4'd0);
        issue();
        check_rv("R9", 1'b1, exp_base + 32'h11);
    endtask

    task automatic t_negwrap();
        load_base(32'h0000_0010);
        set_slot(0, 1'b1, 1'b0, 16'hFFE0, 16'h0, 4'd0);
        pred = 3'b001;
        issue();
        check_rv("R10", 1'b1, 32'hFFFF_FFF0);
        set_slot(0, 1'b1, 1'b0, 16'h0020, 16'h0, 4'd0);
        issue();
        check_rv("R10", 1'b1, 32'h0000_0010);
        pred = 3'b000;
    endtask

    task automatic t_notaken();
        set_slot(0, 1'b0, 1'b0, 16'h0070, 16'h0, 4'd1);
        set_slot(1, 1'b0, 1'b0, 16'h0090, 16'h0, 4'd2);
        pred = 3'b000;
        issue();
        pred = 3'b011; tick(); check_rv("R11", 1'b0, '0);
        pred = 3'b001; tick(); check_rv("R11", 1'b1, exp_base + 32'h90);
        pred = 3'b000;
    endtask

    task automatic t_load();
        logic [AW-1:0] b;
        b = exp_base;
        entry_load = 1'b1;
        entry_addr = 32'h0000_9000;
        set_slot(0, 1'b1, 1'b0, 16'h0008, 16'h0, 4'd0);
        pred = 3'b001;
        issue();
        entry_load = 1'b0;
        check_rv("R12", 1'b1, b + 32'h8);
        set_slot(0, 1'b1, 1'b0, 16'h0004, 16'h0, 4'd0);
        issue();
        check_rv("R12", 1'b1, b + 32'hC);
        load_base(32'h0000_9000);
        set_slot(0, 1'b1, 1'b0, 16'h0004, 16'h0, 4'd0);
        issue();
        check_rv("R12", 1'b1, 32'h0000_9004);
        pred = 3'b000;
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    initial begin
        repeat (3) tick();
        rst = 1'b0;
        tick();
        t_reset();
        t_sense();
        t_delay();
        t_priority();
        t_earliest();
        t_opsel();
        t_negwrap();
        t_notaken();
        t_load();
        tick();
        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not complete, actual hung, expected done");
            summary();
            $finish;
        end
    end

endmodule